// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is one bank of up to 32 general-purpose pins. It sits behind a simple 32-bit register bus. Each pin carries its own output value, interrupt mask, pull-up disable, function enable, select, direction and trigger bit, plus a sticky event flag. Software changes these bits only through write-one-to-set and write-one-to-clear aliases, so one write never touches a pin it did not name. Reads return the register at the group's base offset, or the synchronized live pin levels at offset 0x00.

The function enable, select, direction and trigger bits together pick the pin's role. With function enable low and select low, the pin is a plain GPIO whose direction bit drives output enable. With function enable low and select high, the pin is an interrupt input, and direction and trigger choose the polarity and whether it detects edges or levels. With function enable high, select and trigger pick one of three alternate-function output sets. Detected events set flag bits. The bank interrupt is the OR of every flag whose mask bit is clear. A pin-count parameter removes the upper pins: their bits read as zero and ignore writes.

Top module: `gpio_irq_bank`

## Requirements
- R1: After synchronous reset every register reads 0, every pin_oe bit is 0, every pull_en bit is 1 and irq is 0.
- R2: For the data (0x10), mask (0x20), pull (0x30), function (0x40), select (0x50), direction (0x60) and trigger (0x70) groups, a write to base+4 sets each bit written as 1 and a write to base+8 clears each bit written as 1. Bits written as 0 keep their value. A write to the base offset changes nothing, and a read of the base offset returns the register.
- R3: A read of offset 0x00 returns the pin_in levels after a two-flop synchronizer. A change on pin_in appears in the read value after two rising clock edges, and not after one.
- R4: With function=0 and select=0, pin_oe equals the direction bit and pin_out equals the data bit.
- R5: With function=1, select=0 routes alt1_out/alt1_oe to the pin. Select=1 with trigger=0 routes alt2, and select=1 with trigger=1 routes alt3.
- R6: With function=0, select=1 and trigger=0, the flag bit is set while the synchronized level equals the direction bit (1 means high level, 0 means low level).
- R7: With function=0, select=1 and trigger=1, the flag bit is set only on a change of the synchronized level. Direction=1 picks a 0-to-1 change and direction=0 picks a 1-to-0 change. A steady level sets nothing.
- R8: irq is the OR over pins of flag AND NOT mask. A masked pin still records its flag.
- R9: Flag bits read at 0x80. They are cleared by writing ones to 0x88, and a write to 0x80 has no effect. When a new event and a clear hit the same bit in the same cycle, the bit stays set.
- R10: pull_en is the bitwise inverse of the pull register.
- R11: With NUM_PINS below 32, the bits at and above NUM_PINS read as 0 in every register and in the pin read, and writes to them are ignored.
- R12: rdata is 0 while rd_en is low, and it is 0 when the address is a set or clear alias.
- R13: A pin in interrupt mode (function=0, select=1) never drives: its pin_oe bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational from address |
| pin_in | input | NUM_PINS | Raw pin levels from the pads |
| pin_out | output | NUM_PINS | Value driven to the pads |
| pin_oe | output | NUM_PINS | Pad output enable |
| pull_en | output | NUM_PINS | Pull-up enable per pad |
| alt1_out | input | NUM_PINS | Alternate function 1 output values |
| alt1_oe | input | NUM_PINS | Alternate function 1 output enables |
| alt2_out | input | NUM_PINS | Alternate function 2 output values |
| alt2_oe | input | NUM_PINS | Alternate function 2 output enables |
| alt3_out | input | NUM_PINS | Alternate function 3 output values |
| alt3_oe | input | NUM_PINS | Alternate function 3 output enables |
| irq | output | 1 | Combined bank interrupt |

## Verification
An acknowledge write and a fresh detection can land on the same flag bit in the same cycle. The bench provokes this with a high-level interrupt pin held high while software writes its clear bit. It samples the flag in the cycle right after the clear edge, before any later detection could set the bit again. The flag must still read 1 there. A clear with no competing event, on an edge-mode pin, must bring the bit to 0 on the same edge.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;

    // access kind in the low nibble of the address
    localparam logic [3:0] ACC_BASE = 4'h0;
    localparam logic [3:0] ACC_SET  = 4'h4;
    localparam logic [3:0] ACC_CLR  = 4'h8;

    // register groups in the high nibble
    localparam logic [3:0] GRP_PIN  = 4'h0;
    localparam logic [3:0] GRP_DATA = 4'h1;
    localparam logic [3:0] GRP_MASK = 4'h2;
    localparam logic [3:0] GRP_PULL = 4'h3;
    localparam logic [3:0] GRP_FUNC = 4'h4;
    localparam logic [3:0] GRP_SEL  = 4'h5;
    localparam logic [3:0] GRP_DIR  = 4'h6;
    localparam logic [3:0] GRP_TRIG = 4'h7;
    localparam logic [3:0] GRP_FLAG = 4'h8;

    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic [BUS_W-1:0] mask;
        logic [BUS_W-1:0] pull;
        logic [BUS_W-1:0] func;
        logic [BUS_W-1:0] sel;
        logic [BUS_W-1:0] dir;
        logic [BUS_W-1:0] trig;
    } ctrl_t;

    typedef enum logic [2:0] {
        MODE_GPIO,
        MODE_IRQ,
        MODE_ALT1,
        MODE_ALT2,
        MODE_ALT3
    } pin_mode_e;

    function automatic pin_mode_e pin_mode(input logic fen, input logic sel, input logic trig);
        if (!fen)      return sel ? MODE_IRQ : MODE_GPIO;
        else if (!sel) return MODE_ALT1;
        else           return trig ? MODE_ALT3 : MODE_ALT2;
    endfunction

    // apply a set or clear alias write to one control register
    function automatic logic [BUS_W-1:0] apply_wr(
        input logic [BUS_W-1:0]  cur,
        input logic [BUS_W-1:0]  wd,
        input logic              we,
        input logic [ADDR_W-1:0] addr,
        input logic [3:0]        grp,
        input logic [BUS_W-1:0]  impl
    );
        logic [BUS_W-1:0] nxt;
        nxt = cur;
        if (we && addr[7:4] == grp) begin
            if (addr[3:0] == ACC_SET)      nxt = cur | wd;
            else if (addr[3:0] == ACC_CLR) nxt = cur & ~wd;
        end
        return nxt & impl;
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
`timescale 1ns/1ps
module gpio_bank_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prv
);
    logic [W-1:0] meta_q, lvl_q, prv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prv_q  <= '0;
        end else begin
            meta_q <= raw;
            lvl_q  <= meta_q;
            prv_q  <= lvl_q;
        end
    end

    assign lvl = lvl_q;
    assign prv = prv_q;
endmodule

// File: rtl/gpio_bank_detect.sv
`timescale 1ns/1ps
module gpio_bank_detect
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic [NUM_PINS-1:0] func,
    input  logic [NUM_PINS-1:0] sel,
    input  logic [NUM_PINS-1:0] dir,
    input  logic [NUM_PINS-1:0] trig,
    input  logic [NUM_PINS-1:0] lvl,
    input  logic [NUM_PINS-1:0] prv,
    output logic [NUM_PINS-1:0] evt
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_mode_e mode;
        logic      lvl_hit, edge_hit;
        assign mode     = pin_mode(func[i], sel[i], trig[i]);
        assign lvl_hit  = (lvl[i] == dir[i]);
        assign edge_hit = dir[i] ? (lvl[i] & ~prv[i]) : (~lvl[i] & prv[i]);
        assign evt[i]   = (mode == MODE_IRQ) && (trig[i] ? edge_hit : lvl_hit);
    end
endmodule

// File: rtl/gpio_bank_mux.sv
`timescale 1ns/1ps
module gpio_bank_mux
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] func,
    input  logic [NUM_PINS-1:0] sel,
    input  logic [NUM_PINS-1:0] dir,
    input  logic [NUM_PINS-1:0] trig,
    input  logic [NUM_PINS-1:0] data,
    input  logic [NUM_PINS-1:0] a1_out,
    input  logic [NUM_PINS-1:0] a1_oe,
    input  logic [NUM_PINS-1:0] a2_out,
    input  logic [NUM_PINS-1:0] a2_oe,
    input  logic [NUM_PINS-1:0] a3_out,
    input  logic [NUM_PINS-1:0] a3_oe,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_mode_e mode;
        assign mode = pin_mode(func[i], sel[i], trig[i]);
        always_comb begin
            case (mode)
                MODE_GPIO: begin pin_out[i] = data[i];   pin_oe[i] = dir[i];   end
                MODE_ALT1: begin pin_out[i] = a1_out[i]; pin_oe[i] = a1_oe[i]; end
                MODE_ALT2: begin pin_out[i] = a2_out[i]; pin_oe[i] = a2_oe[i]; end
                MODE_ALT3: begin pin_out[i] = a3_out[i]; pin_oe[i] = a3_oe[i]; end
                default:   begin pin_out[i] = data[i];   pin_oe[i] = 1'b0;     end
            endcase
        end
    end

    // R13
    irq_pin_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        ((~func & sel & pin_oe) == '0));
endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                we,
    input  logic [BUS_W-1:0]    wdata,
    input  logic                re,
    output logic [BUS_W-1:0]    rdata,
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic [NUM_PINS-1:0] evt,
    output ctrl_t               ctrl,
    output logic [BUS_W-1:0]    flag
);
    localparam logic [BUS_W-1:0] IMPL = {BUS_W{1'b1}} >> (BUS_W - NUM_PINS);

    logic [BUS_W-1:0] lvl_w, evt_w, ack_w;
    logic             ack_hit;

    assign lvl_w   = BUS_W'(pin_lvl);
    assign evt_w   = BUS_W'(evt);
    assign ack_hit = we && addr[7:4] == GRP_FLAG && addr[3:0] == ACC_CLR;
    assign ack_w   = ack_hit ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            flag <= '0;
        end else begin
            ctrl.data <= apply_wr(ctrl.data, wdata, we, addr, GRP_DATA, IMPL);
            ctrl.mask <= apply_wr(ctrl.mask, wdata, we, addr, GRP_MASK, IMPL);
            ctrl.pull <= apply_wr(ctrl.pull, wdata, we, addr, GRP_PULL, IMPL);
            ctrl.func <= apply_wr(ctrl.func, wdata, we, addr, GRP_FUNC, IMPL);
            ctrl.sel  <= apply_wr(ctrl.sel,  wdata, we, addr, GRP_SEL,  IMPL);
            ctrl.dir  <= apply_wr(ctrl.dir,  wdata, we, addr, GRP_DIR,  IMPL);
            ctrl.trig <= apply_wr(ctrl.trig, wdata, we, addr, GRP_TRIG, IMPL);
            // a new event overrides an acknowledge on the same bit
            flag      <= ((flag & ~ack_w) | evt_w) & IMPL;
        end
    end

    always_comb begin
        rdata = '0;
        if (re && addr[3:0] == ACC_BASE) begin
            case (addr[7:4])
                GRP_PIN:  rdata = lvl_w;
                GRP_DATA: rdata = ctrl.data;
                GRP_MASK: rdata = ctrl.mask;
                GRP_PULL: rdata = ctrl.pull;
                GRP_FUNC: rdata = ctrl.func;
                GRP_SEL:  rdata = ctrl.sel;
                GRP_DIR:  rdata = ctrl.dir;
                GRP_TRIG: rdata = ctrl.trig;
                GRP_FLAG: rdata = flag;
                default:  rdata = '0;
            endcase
        end
    end

    // R2
    base_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr[3:0] == ACC_BASE) |=> $stable(ctrl));

    // R2
    data_set_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == {GRP_DATA, ACC_SET}) |=>
        ((ctrl.data & $past(wdata) & IMPL) == ($past(wdata) & IMPL)));

    // R9
    event_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt_w) |=> ((flag & $past(evt_w)) == $past(evt_w)));
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [7:0]          bus_addr,
    input  logic                wr_en,
    input  logic [31:0]         wr_data,
    input  logic                rd_en,
    output logic [31:0]         rd_data,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pull_en,
    input  logic [NUM_PINS-1:0] alt1_out,
    input  logic [NUM_PINS-1:0] alt1_oe,
    input  logic [NUM_PINS-1:0] alt2_out,
    input  logic [NUM_PINS-1:0] alt2_oe,
    input  logic [NUM_PINS-1:0] alt3_out,
    input  logic [NUM_PINS-1:0] alt3_oe,
    output logic                irq
);
    ctrl_t               ctrl;
    logic [BUS_W-1:0]    flag;
    logic [NUM_PINS-1:0] lvl, prv, evt;

    gpio_bank_sync #(.W(NUM_PINS)) u_sync (
        .clk(clk), .rst(rst), .raw(pin_in), .lvl(lvl), .prv(prv)
    );

    gpio_bank_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .func(ctrl.func[NUM_PINS-1:0]), .sel(ctrl.sel[NUM_PINS-1:0]),
        .dir(ctrl.dir[NUM_PINS-1:0]),   .trig(ctrl.trig[NUM_PINS-1:0]),
        .lvl(lvl), .prv(prv), .evt(evt)
    );

    gpio_bank_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .we(wr_en), .wdata(wr_data),
        .re(rd_en), .rdata(rd_data), .pin_lvl(lvl), .evt(evt),
        .ctrl(ctrl), .flag(flag)
    );

    gpio_bank_mux #(.NUM_PINS(NUM_PINS)) u_mux (
        .clk(clk), .rst(rst),
        .func(ctrl.func[NUM_PINS-1:0]), .sel(ctrl.sel[NUM_PINS-1:0]),
        .dir(ctrl.dir[NUM_PINS-1:0]),   .trig(ctrl.trig[NUM_PINS-1:0]),
        .data(ctrl.data[NUM_PINS-1:0]),
        .a1_out(alt1_out), .a1_oe(alt1_oe),
        .a2_out(alt2_out), .a2_oe(alt2_oe),
        .a3_out(alt3_out), .a3_oe(alt3_oe),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    assign pull_en = ~ctrl.pull[NUM_PINS-1:0];
    assign irq     = |(flag & ~ctrl.mask);

    // R8
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ((flag != $past(flag)) || (ctrl.mask != $past(ctrl.mask))));
endmodule

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data, rd_data_n;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe, pull_en;
    logic [31:0] a1o = '0, a1e = '0, a2o = '0, a2e = '0, a3o = '0, a3e = '0;
    logic        irq, irq_n;
    logic [30:0] pin_out_n, pin_oe_n, pull_en_n;

    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_irq_bank u_gpio_irq_bank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pull_en(pull_en),
        .alt1_out(a1o), .alt1_oe(a1e), .alt2_out(a2o), .alt2_oe(a2e),
        .alt3_out(a3o), .alt3_oe(a3e), .irq(irq)
    );

    gpio_irq_bank #(.NUM_PINS(31)) u_gpio_irq_bank_n31 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data_n), .pin_in(pin_in[30:0]), .pin_out(pin_out_n),
        .pin_oe(pin_oe_n), .pull_en(pull_en_n),
        .alt1_out(a1o[30:0]), .alt1_oe(a1e[30:0]), .alt2_out(a2o[30:0]), .alt2_oe(a2e[30:0]),
        .alt3_out(a3o[30:0]), .alt3_oe(a3e[30:0]), .irq(irq_n)
    );

    // write address, write data, read address, expected read
    localparam logic [79:0] VEC [12] = '{
        {8'h14, 32'hFFFF0000, 8'h10, 32'hFFFF0000},
        {8'h18, 32'h0F000000, 8'h10, 32'hF0FF0000},
        {8'h10, 32'h12345678, 8'h10, 32'hF0FF0000},
        {8'h24, 32'h000000FF, 8'h20, 32'h000000FF},
        {8'h28, 32'h0000000F, 8'h20, 32'h000000F0},
        {8'h44, 32'h80000001, 8'h40, 32'h80000001},
        {8'h54, 32'h00000300, 8'h50, 32'h00000300},
        {8'h68, 32'hFFFFFFFF, 8'h60, 32'h00000000},
        {8'h64, 32'h00FF00FF, 8'h60, 32'h00FF00FF},
        {8'h74, 32'h0F0F0000, 8'h70, 32'h0F0F0000},
        {8'h78, 32'h0F000000, 8'h70, 32'h000F0000},
        {8'h34, 32'hAAAA5555, 8'h30, 32'hAAAA5555}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v, output logic [31:0] vn);
        @(negedge clk);
        bus_addr = a; rd_en = 1'b1;
        #1;
        v = rd_data; vn = rd_data_n;
        rd_en = 1'b0;
    endtask

    // write, then read in the very next cycle
    task automatic wr_rd(input logic [7:0] wa, input logic [31:0] d, input logic [7:0] ra,
                         output logic [31:0] v);
        @(negedge clk);
        bus_addr = wa; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; bus_addr = ra; rd_en = 1'b1;
        #1;
        v = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pin_in = '0;
        a1o = '0; a1e = '0; a2o = '0; a2e = '0; a3o = '0; a3e = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, vn;

        // R1 reset state
        do_reset();
        for (int g = 0; g < 9; g++) begin
            rd(8'(g << 4), v, vn);
            check("R1 register reset", v, 32'h0);
        end
        check("R1 pin_oe reset", pin_oe, 32'h0);
        check("R1 pull_en reset", pull_en, 32'hFFFFFFFF);
        check("R1 irq reset", {31'h0, irq}, 32'h0);

        // R2 set/clear alias table
        for (int i = 0; i < 12; i++) begin
            wr(VEC[i][79:72], VEC[i][71:40]);
            rd(VEC[i][39:32], v, vn);
            check("R2 alias write", v, VEC[i][31:0]);
        end

        // R12 read strobe low and alias addresses
        @(negedge clk);
        bus_addr = 8'h10; rd_en = 1'b0;
        #1;
        check("R12 rd_en low", rd_data, 32'h0);
        rd(8'h14, v, vn);
        check("R12 alias read", v, 32'h0);

        // R3 synchronizer latency
        do_reset();
        @(negedge clk);
        pin_in = 32'hA5A50000;
        bus_addr = 8'h00; rd_en = 1'b1;
        @(negedge clk);
        #1;
        check("R3 pin after one edge", rd_data, 32'h0);
        @(negedge clk);
        #1;
        check("R3 pin after two edges", rd_data, 32'hA5A50000);
        rd_en = 1'b0;

        // R4 plain GPIO
        do_reset();
        wr(8'h64, 32'h000000FF);
        wr(8'h14, 32'h0000000F);
        check("R4 oe follows direction", pin_oe, 32'h000000FF);
        check("R4 out follows data", pin_out & 32'hFF, 32'h0000000F);

        // R10 pull-up enable
        wr(8'h34, 32'h0000FFFF);
        check("R10 pull_en inverse", pull_en, 32'hFFFF0000);

        // R5 alternate function selection: pin0 alt1, pin1 alt2, pin2 alt3
        do_reset();
        wr(8'h44, 32'h7);
        wr(8'h54, 32'h6);
        wr(8'h74, 32'h4);
        @(negedge clk);
        a1o = 32'h1; a2o = 32'h2; a3o = 32'h4;
        a1e = 32'h1; a2e = 32'h2; a3e = 32'h4;
        #1;
        check("R5 alt out routing", pin_out & 32'h7, 32'h7);
        check("R5 alt oe routing", pin_oe & 32'h7, 32'h7);
        @(negedge clk);
        a1o = 32'h6; a2o = 32'h5; a3o = 32'h3;
        #1;
        check("R5 alt out exclusion", pin_out & 32'h7, 32'h0);

        // R6 level interrupts: pin4 high level, pin5 low level
        do_reset();
        wr(8'h54, 32'h30);
        wr(8'h64, 32'h10);
        idle(4);
        wr(8'h88, 32'hFFFFFFFF);
        idle(1);
        rd(8'h80, v, vn);
        check("R6 low-level fires, high-level idle", v, 32'h20);
        check("R13 irq pins not driven", pin_oe & 32'h30, 32'h0);
        @(negedge clk);
        pin_in[4] = 1'b1;
        idle(4);
        rd(8'h80, v, vn);
        check("R6 high level fires", v, 32'h30);
        // R9 event wins over simultaneous clear
        wr_rd(8'h88, 32'h10, 8'h80, v);
        check("R9 event beats clear", v & 32'h10, 32'h10);
        @(negedge clk);
        pin_in[4] = 1'b0;
        idle(4);
        wr(8'h88, 32'h10);
        idle(2);
        rd(8'h80, v, vn);
        check("R6 released level clears", v, 32'h20);

        // R7 edge interrupts: pin8 rising, pin9 falling
        do_reset();
        @(negedge clk);
        pin_in[9] = 1'b1;
        wr(8'h54, 32'h300);
        wr(8'h74, 32'h300);
        wr(8'h64, 32'h100);
        idle(4);
        wr(8'h88, 32'hFFFFFFFF);
        idle(3);
        rd(8'h80, v, vn);
        check("R7 steady levels no flag", v, 32'h0);
        @(negedge clk);
        pin_in[8] = 1'b1;
        idle(4);
        rd(8'h80, v, vn);
        check("R7 rising edge flag", v, 32'h100);
        check("R8 irq on unmasked flag", {31'h0, irq}, 32'h1);
        wr_rd(8'h88, 32'h100, 8'h80, v);
        check("R9 clear without event", v, 32'h0);
        idle(4);
        rd(8'h80, v, vn);
        check("R7 held high no new flag", v, 32'h0);
        @(negedge clk);
        pin_in[9] = 1'b0;
        idle(4);
        rd(8'h80, v, vn);
        check("R7 falling edge flag", v, 32'h200);
        wr(8'h88, 32'h200);
        @(negedge clk);
        pin_in[8] = 1'b0;
        idle(4);
        rd(8'h80, v, vn);
        check("R7 falling on rising pin ignored", v, 32'h0);

        // R8 masking
        wr(8'h24, 32'h100);
        @(negedge clk);
        pin_in[8] = 1'b1;
        idle(4);
        rd(8'h80, v, vn);
        check("R8 masked flag still recorded", v, 32'h100);
        check("R8 masked irq low", {31'h0, irq}, 32'h0);
        wr(8'h28, 32'h100);
        check("R8 unmask raises irq", {31'h0, irq}, 32'h1);
        // R9 base write to flag ignored
        wr(8'h80, 32'hFFFFFFFF);
        rd(8'h80, v, vn);
        check("R9 flag base write ignored", v, 32'h100);

        // R11 narrow bank
        do_reset();
        wr(8'h14, 32'hFFFFFFFF);
        rd(8'h10, v, vn);
        check("R11 narrow data register", vn, 32'h7FFFFFFF);
        check("R11 full data register", v, 32'hFFFFFFFF);
        @(negedge clk);
        pin_in = 32'hFFFFFFFF;
        idle(3);
        rd(8'h00, v, vn);
        check("R11 narrow pin read", vn, 32'h7FFFFFFF);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule